// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block watches a two-wire serial bus and treats one specific bus pattern as proof that the host is alive. The pattern is a START condition (SDA falls while SCL is high) followed, at any later time, by a STOP condition (SDA rises while SCL is high). When that pair completes, the timeout counter restarts. If the pair does not complete within the selected period, the block emits a one-cycle expiry pulse toward the reset sequencer. After a pulse the count starts again, so a silent host gets a pulse once every period.

The bus lines are asynchronous to the system clock. Each line passes through a two-flop synchronizer, and edges are detected on the synchronized values. A 2-bit code selects one of three timeout periods, or turns the watchdog off. Each period is a parameter given in clock ticks, nominally scaled to 200 ms, 600 ms and 1.4 s. Full data transfer, storage of the setting and analog glitch filtering belong to other blocks.

Top module: `bus_watchdog`

## Requirements
- R1: While reset is asserted and in the cycles right after its release with the off code selected, `expire_o` is low.
- R2: With no restart, `expire_o` pulses high for exactly one cycle once every selected period, measured from the last restart.
- R3: Code `2'b00` selects `PERIOD_T0` ticks, `2'b01` selects `PERIOD_T1` and `2'b10` selects `PERIOD_T2`. After a restart at edge E, the pulse is registered at edge E plus the period.
- R4: Code `2'b11` holds the counter at zero and produces no pulse. Leaving the off code starts a full period from zero.
- R5: Any change of `period_sel` restarts the count at the first clock edge that sees the new code.
- R6: A STOP that follows a START restarts the count. An SDA rise driven while SCL is high counts as the STOP. The counter is cleared at the third clock edge after that SDA rise.
- R7: A STOP with no pending START has no effect on the count.
- R8: A START that is not followed by a STOP does not restart the count.
- R9: A repeated START, issued before the STOP, leaves the detector armed. The later STOP still restarts the count.
- R10: SDA transitions while SCL is low are neither START nor STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Serial bus clock line, asynchronous |
| sda_i | input | 1 | Serial bus data line, asynchronous |
| period_sel | input | 2 | Timeout code: 00/01/10 select a period, 11 disables |
| expire_o | output | 1 | One-cycle expiry pulse to the reset sequencer |

## Verification
A corrupted count or a wrong period decode appears only at `expire_o`, and only when the next pulse is due. It shows as a pulse that comes too early, too late or not at all, up to one full period after the fault. A wrong armed flag shows up differently. A lost arm hides a valid restart, and a false arm turns a stray STOP into a restart. Either way the next pulse moves by the difference between the restart points. The bench therefore predicts the exact cycle of every pulse from the driven bus edges and code changes. It also flags any pulse that is extra, missing or shifted.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  typedef enum logic [1:0] {
    WD_SEL_P0  = 2'b00,
    WD_SEL_P1  = 2'b01,
    WD_SEL_P2  = 2'b10,
    WD_SEL_OFF = 2'b11
  } wd_sel_e;

  localparam int BUS_LINES = 2;
  localparam int LINE_SCL  = 1;
  localparam int LINE_SDA  = 0;
endpackage

// File: rtl/bus_line_sync.sv
`timescale 1ns/1ps
module bus_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] line_o
);
  // Idle bus is high, so every stage resets to 1.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], line_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign line_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/bus_kick_detect.sv
`timescale 1ns/1ps
module bus_kick_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic kick_o
);
  logic scl_p_q, sda_p_q, armed_q;
  logic armed_d;
  logic start_evt, stop_evt;

  // Edge qualification requires SCL high on both samples around the SDA edge.
  always_comb begin
    start_evt = scl_s & scl_p_q & sda_p_q & ~sda_s;
    stop_evt  = scl_s & scl_p_q & ~sda_p_q & sda_s;
    armed_d   = armed_q;
    if (start_evt)     armed_d = 1'b1;
    else if (stop_evt) armed_d = 1'b0;
    kick_o    = stop_evt & armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      scl_p_q <= scl_s;
      sda_p_q <= sda_s;
      armed_q <= armed_d;
    end
  end

  AST_NO_DOUBLE_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    kick_o |=> !kick_o); // R7

  AST_START_NOT_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !kick_o); // R8
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int PERIOD_T0 = 20_000_000,
  parameter int PERIOD_T1 = 60_000_000,
  parameter int PERIOD_T2 = 140_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  input  logic       kick_i,
  output logic       expire_o
);
  localparam int MAX01 = (PERIOD_T0 > PERIOD_T1) ? PERIOD_T0 : PERIOD_T1;
  localparam int MAXP  = (MAX01 > PERIOD_T2) ? MAX01 : PERIOD_T2;
  localparam int CNT_W = $clog2(MAXP + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, last_d;
  logic [1:0]       sel_q;
  logic             exp_q, exp_d;
  logic             enable, code_chg, restart;

  always_comb begin
    case (sel_i)
      WD_SEL_P0: last_d = CNT_W'(PERIOD_T0 - 1);
      WD_SEL_P1: last_d = CNT_W'(PERIOD_T1 - 1);
      WD_SEL_P2: last_d = CNT_W'(PERIOD_T2 - 1);
      default:   last_d = '0;
    endcase
  end

  always_comb begin
    enable   = (sel_i != WD_SEL_OFF);
    code_chg = (sel_i != sel_q);
    restart  = kick_i | code_chg;
    cnt_d    = cnt_q;
    exp_d    = 1'b0;
    if (!enable) begin
      cnt_d = '0;
    end else if (restart) begin
      cnt_d = '0;
    end else if (cnt_q == last_d) begin
      cnt_d = '0;
      exp_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= WD_SEL_OFF;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_i;
      exp_q <= exp_d;
    end
  end

  assign expire_o = exp_q;

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o); // R2

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == WD_SEL_OFF) |=> !expire_o); // R4

  AST_CHANGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i != sel_q) |=> (!expire_o && cnt_q == '0)); // R5

  AST_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> !expire_o); // R6
endmodule

// File: rtl/bus_watchdog.sv
`timescale 1ns/1ps
module bus_watchdog
  import wdt_pkg::*;
#(
  parameter int PERIOD_T0   = 20_000_000,
  parameter int PERIOD_T1   = 60_000_000,
  parameter int PERIOD_T2   = 140_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] period_sel,
  output logic       expire_o
);
  logic [BUS_LINES-1:0] raw_lines, sync_lines;
  logic                 kick;

  assign raw_lines[LINE_SCL] = scl_i;
  assign raw_lines[LINE_SDA] = sda_i;

  bus_line_sync #(.LINES(BUS_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (raw_lines),
    .line_o (sync_lines)
  );

  bus_kick_detect u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_s  (sync_lines[LINE_SCL]),
    .sda_s  (sync_lines[LINE_SDA]),
    .kick_o (kick)
  );

  wdt_counter #(
    .PERIOD_T0 (PERIOD_T0),
    .PERIOD_T1 (PERIOD_T1),
    .PERIOD_T2 (PERIOD_T2)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (period_sel),
    .kick_i   (kick),
    .expire_o (expire_o)
  );
endmodule

// File: tb/bus_watchdog_test.sv
`timescale 1ns/1ps
module bus_watchdog_test;
  localparam int T0 = 40;
  localparam int T1 = 100;
  localparam int T2 = 160;

  logic       clk = 1'b0;
  logic       rst_n, scl, sda;
  logic [1:0] sel;
  logic       expire;
  int         cyc = 0;
  int         compared = 0;
  int         mismatched = 0;
  int         exp_q[$];
  string      tag_q[$];
  string      phase = "R1";
  bit         done = 1'b0;

  bus_watchdog #(.PERIOD_T0(T0), .PERIOD_T1(T1), .PERIOD_T2(T2)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .period_sel(sel), .expire_o(expire)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops predicted pulse cycles and compares them with observed pulses.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() > 0 && exp_q[0] < cyc) begin
        compared++; mismatched++;
        $display("FAIL %s: pulse missing, actual none by cycle %0d, expected cycle %0d",
                 tag_q[0], cyc, exp_q[0]);
        void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end
      if (expire) begin
        compared++;
        if (exp_q.size() == 0) begin
          mismatched++;
          $display("FAIL %s: unexpected pulse, actual cycle %0d, expected none", phase, cyc);
        end else begin
          if (exp_q[0] != cyc) begin
            mismatched++;
            $display("FAIL %s: pulse timing, actual cycle %0d, expected cycle %0d",
                     tag_q[0], cyc, exp_q[0]);
          end
          void'(exp_q.pop_front()); void'(tag_q.pop_front());
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic push(input int t, input string tag);
    exp_q.push_back(t); tag_q.push_back(tag);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d, expected %0d", req, act, expv);
    end
  endtask

  task automatic set_sel(input logic [1:0] code, output int e);
    @(negedge clk);
    sel = code;
    e = cyc + 1;
  endtask

  task automatic start_seq();   // from SCL=1, SDA=1
    sda = 1'b0; step(3);
    scl = 1'b0; step(3);
  endtask

  task automatic stop_seq(output int e);   // from SCL=0
    sda = 1'b0; step(3);
    scl = 1'b1; step(3);
    sda = 1'b1;
    e = cyc + 3;
    step(3);
  endtask

  task automatic data_toggle();   // SCL held low
    sda = 1'b1; step(2);
    sda = 1'b0; step(2);
    sda = 1'b1; step(2);
  endtask

  initial begin
    int e;
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; sel = 2'b11;
    step(5);
    check(expire == 1'b0, "R1", expire, 0);
    @(negedge clk) rst_n = 1'b1;
    step(3);
    check(expire == 1'b0, "R1", expire, 0);
    phase = "R4";
    step(200);

    phase = "R2";
    set_sel(2'b00, e);
    push(e + T0, "R3"); push(e + 2*T0, "R2"); push(e + 3*T0, "R2");
    wait_until(e + 3*T0 + 5);

    phase = "R5";
    set_sel(2'b01, e);
    push(e + T1, "R5");
    wait_until(e + T1 + 5);

    phase = "R6";
    start_seq();
    data_toggle();
    stop_seq(e);
    push(e + T1, "R6");
    wait_until(e + T1 + 5);

    phase = "R10";
    set_sel(2'b10, e);
    push(e + T2, "R10"); push(e + 2*T2, "R8");
    step(20);
    scl = 1'b0; step(3);
    sda = 1'b0; step(3);
    sda = 1'b1; step(3);
    sda = 1'b0; step(3);
    scl = 1'b1; step(3);
    phase = "R7";
    sda = 1'b1; step(3);
    wait_until(e + T2 + 10);

    phase = "R8";
    start_seq();
    step(5);
    wait_until(e + 2*T2 + 10);

    phase = "R9";
    sda = 1'b1; step(3);
    scl = 1'b1; step(3);
    sda = 1'b0; step(3);
    scl = 1'b0; step(3);
    data_toggle();
    stop_seq(e);
    push(e + T2, "R9");
    wait_until(e + T2 + 5);

    phase = "R4";
    set_sel(2'b11, e);
    step(400);
    set_sel(2'b00, e);
    push(e + T0, "R4");
    wait_until(e + T0 + 5);

    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    check(expire == 1'b0, "R2", expire, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung at cycle %0d, expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule